// File: doc/BRIEF.md
# Serial-Programmed Potentiometer Control Core

This block is the digital side of a 1024-step digital potentiometer. A host sends 16-bit command words over a SPI-style link: an active-low frame select, a serial clock and a data line. The core decodes each word when the frame closes. It keeps a 10-bit wiper register, a two-bit control register and a shutdown flag, and presents all three to the analog resistor array as plain outputs. A ready flag tells the host when a wiper write or a register read has finished. An open-drain style data output returns register contents in the frame that follows a read command. Otherwise it passes the shifted bits on, so that several cores can share one chain.

All serial inputs and the hardware reset input are brought into the system clock domain through a synchronizer and handled as edges there. Busy periods are counted in system clock cycles. The wiper write time depends on whether the calibrated performance mode is active. The power-on reset is the asynchronous active-low `rstN`. The hardware reset input acts only on its rising edge.

Top module: `potCore`

## Requirements
- R1: A frame is shifted MSB first, one bit on each falling edge of `sclk` while `syncN` is low. The command sits in bits 13..10 of the 16-bit word and the data in bits 9..0.
- R2: A frame is decoded only when `syncN` rises after a nonzero multiple of 16 bits, and then the last 16 bits received are used. Any other count (15, 17, 31, 33) changes nothing. Command 0 and the unused codes 7..15 change nothing.
- R3: Command 1 loads the data field into `wiperCode` only while the write-enable control bit is 1. While that bit is 0, which is its reset value, the command has no effect.
- R4: Command 4 loads the control register. Data bit 2 selects the mode (0 = performance mode, seen as `perfMode` = 1; 1 = normal mode), and data bit 1 is the wiper write enable.
- R5: Command 3 sets `wiperCode` to 0x200, clears write enable and returns to performance mode, even while writes are locked.
- R6: After power-on reset, `wiperCode` = 0x200, `perfMode` = 1, `shutdown` = 0, `ready` = 1, writes are locked and `sdoPullLow` = 0.
- R7: A rising edge on `hwReset` sets `wiperCode` to 0x200, whether or not writes are locked. Holding the input high or letting it fall has no further effect, and it leaves the control register unchanged.
- R8: Command 6 sets `shutdown` to data bit 0. The wiper register is unchanged, and all commands keep working while in shutdown.
- R9: After command 2 (wiper) or command 5 (control), the next frame shifts out a 16-bit word with the register in its low 10 bits and zeros above. The control word carries the mode in bit 2 and write enable in bit 1.
- R10: With no read pending, the next frame shifts out the 16 bits of the previous frame, MSB first. `sdoPullLow` is 1 for a 0 bit and 0 for a 1 bit, and is 0 while `syncN` is high.
- R11: `ready` goes low for exactly WR_PERF_CYCLES cycles after a command 1 in performance mode, WR_NORM_CYCLES in normal mode, and RD_CYCLES after command 2 or 5. Other commands leave it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| hwReset | input | 1 | Hardware reset, acts on its rising edge |
| syncN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdi | input | 1 | Serial data in |
| sdoPullLow | output | 1 | Open-drain enable for serial out: 1 pulls the line low |
| ready | output | 1 | High when no write or read is in progress |
| wiperCode | output | 10 | Wiper position for the resistor array |
| perfMode | output | 1 | Calibrated performance mode active |
| shutdown | output | 1 | Array in shutdown |

## Verification
The bench goes after frame length. It sends 15-, 17-, 31- and 33-bit frames whose trailing 16 bits form a valid write, and a correct 32-bit frame. A core that decoded on any 16-bit boundary, or on the raw last 16 bits, would move the wiper on the bad frames. It checks write locking through software reset, hardware reset and shutdown. A core that let the reset paths honour the lock would be left stuck off midscale, and one that cleared the wiper on shutdown would read back zero. Readback and chaining are checked bit by bit on the serial output. The length of each busy period is counted cycle by cycle, which catches a wrong mode selection or an off-by-one in the timer.

// File: rtl/potPkg.sv
package potPkg;
  localparam int CMD_BITS      = 4;
  localparam int CTRL_MODE_BIT = 2;
  localparam int CTRL_WEN_BIT  = 1;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_NOP      = 4'd0,
    CMD_WR_WIPER = 4'd1,
    CMD_RD_WIPER = 4'd2,
    CMD_SW_RESET = 4'd3,
    CMD_WR_CTRL  = 4'd4,
    CMD_RD_CTRL  = 4'd5,
    CMD_SHUTDOWN = 4'd6
  } potCmdE;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftIn;
    logic loadWiper;
    logic loadCtrl;
    logic softReset;
    logic hardReset;
    logic setShutdown;
    logic clrShutdown;
    logic readWiper;
    logic readCtrl;
  } potStrobeT;
endpackage

// File: rtl/potInputSync.sv
module potInputSync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar g = 0; g < WIDTH; g++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RESET_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/potControl.sv
module potControl
  import potPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WR_PERF_CYCLES = 40,
  parameter int WR_NORM_CYCLES = 12,
  parameter int RD_CYCLES = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncLvl,
  input  logic                sclkLvl,
  input  logic                hwLvl,
  input  logic [CMD_BITS-1:0] cmdField,
  input  logic                dataBit0,
  input  logic                writeEn,
  input  logic                perfMode,
  output potStrobeT           strobe,
  output logic                ready,
  output logic                frameValid
);
  localparam int CNT_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam int MAX_AB = (WR_PERF_CYCLES > WR_NORM_CYCLES) ? WR_PERF_CYCLES : WR_NORM_CYCLES;
  localparam int BUSY_MAX = (MAX_AB > RD_CYCLES) ? MAX_AB : RD_CYCLES;
  localparam int BUSY_W = $clog2(BUSY_MAX + 1);

  logic syncPrev, sclkPrev, hwPrev;
  logic syncFall, syncRise, sclkFall, hwRise;
  logic [CNT_W-1:0] bitCnt;
  logic fullSeen;
  logic [BUSY_W-1:0] busyCnt;
  potCmdE cmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b1;
      sclkPrev <= 1'b0;
      hwPrev   <= 1'b0;
    end else begin
      syncPrev <= syncLvl;
      sclkPrev <= sclkLvl;
      hwPrev   <= hwLvl;
    end
  end

  assign syncFall = syncPrev & ~syncLvl;
  assign syncRise = ~syncPrev & syncLvl;
  assign sclkFall = sclkPrev & ~sclkLvl;
  assign hwRise   = ~hwPrev & hwLvl;

  // bit counter modulo the frame length, with a flag for one full word seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      fullSeen <= 1'b0;
    end else if (syncFall) begin
      bitCnt   <= '0;
      fullSeen <= 1'b0;
    end else if (strobe.shiftIn) begin
      if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        fullSeen <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign frameValid = syncRise & fullSeen & (bitCnt == '0);
  assign cmd = potCmdE'(cmdField);

  always_comb begin
    strobe = '0;
    strobe.shiftIn   = sclkFall & ~syncLvl;
    strobe.hardReset = hwRise;
    if (frameValid) begin
      case (cmd)
        CMD_WR_WIPER: strobe.loadWiper = writeEn;
        CMD_RD_WIPER: strobe.readWiper = 1'b1;
        CMD_SW_RESET: strobe.softReset = 1'b1;
        CMD_WR_CTRL:  strobe.loadCtrl  = 1'b1;
        CMD_RD_CTRL:  strobe.readCtrl  = 1'b1;
        CMD_SHUTDOWN: begin
          strobe.setShutdown = dataBit0;
          strobe.clrShutdown = ~dataBit0;
        end
        default: ;
      endcase
    end
  end

  // busy timer, loaded at decode, counts down to idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (frameValid && (cmd == CMD_WR_WIPER)) begin
      busyCnt <= perfMode ? BUSY_W'(WR_PERF_CYCLES) : BUSY_W'(WR_NORM_CYCLES);
    end else if (frameValid && ((cmd == CMD_RD_WIPER) || (cmd == CMD_RD_CTRL))) begin
      busyCnt <= BUSY_W'(RD_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign ready = (busyCnt == '0);
endmodule

// File: rtl/potDatapath.sv
module potDatapath
  import potPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WIPER_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  potStrobeT             strobe,
  input  logic                  sdiLvl,
  input  logic                  syncLvl,
  output logic [CMD_BITS-1:0]   cmdField,
  output logic                  dataBit0,
  output logic [WIPER_BITS-1:0] wiperCode,
  output logic                  writeEn,
  output logic                  perfMode,
  output logic                  shutdown,
  output logic                  sdoPullLow
);
  localparam logic [WIPER_BITS-1:0] MID_CODE = {1'b1, {(WIPER_BITS-1){1'b0}}};

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] wiperWord, ctrlWord;
  logic [WIPER_BITS-1:0] wiperReg;
  logic modeNormal, wenReg, sdReg;

  assign cmdField = shiftReg[WIPER_BITS +: CMD_BITS];
  assign dataBit0 = shiftReg[0];

  always_comb begin
    wiperWord = '0;
    wiperWord[WIPER_BITS-1:0] = wiperReg;
    ctrlWord = '0;
    ctrlWord[CTRL_MODE_BIT] = modeNormal;
    ctrlWord[CTRL_WEN_BIT]  = wenReg;
  end

  // serial register: receives frames, holds readback for the next one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.readWiper) shiftReg <= wiperWord;
    else if (strobe.readCtrl)  shiftReg <= ctrlWord;
    else if (strobe.shiftIn)   shiftReg <= {shiftReg[FRAME_BITS-2:0], sdiLvl};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     wiperReg <= MID_CODE;
    else if (strobe.softReset || strobe.hardReset) wiperReg <= MID_CODE;
    else if (strobe.loadWiper)                     wiperReg <= shiftReg[WIPER_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeNormal <= 1'b0;
      wenReg     <= 1'b0;
    end else if (strobe.softReset) begin
      modeNormal <= 1'b0;
      wenReg     <= 1'b0;
    end else if (strobe.loadCtrl) begin
      modeNormal <= shiftReg[CTRL_MODE_BIT];
      wenReg     <= shiftReg[CTRL_WEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sdReg <= 1'b0;
    else if (strobe.setShutdown) sdReg <= 1'b1;
    else if (strobe.clrShutdown) sdReg <= 1'b0;
  end

  assign wiperCode  = wiperReg;
  assign writeEn    = wenReg;
  assign perfMode   = ~modeNormal;
  assign shutdown   = sdReg;
  assign sdoPullLow = ~syncLvl & ~shiftReg[FRAME_BITS-1];
endmodule

// File: rtl/potCore.sv
module potCore
  import potPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int WIPER_BITS = 10,
  parameter int SYNC_STAGES = 2,
  parameter int WR_PERF_CYCLES = 40,
  parameter int WR_NORM_CYCLES = 12,
  parameter int RD_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hwReset,
  input  logic                  syncN,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdoPullLow,
  output logic                  ready,
  output logic [WIPER_BITS-1:0] wiperCode,
  output logic                  perfMode,
  output logic                  shutdown
);
  logic [3:0] syncVec;
  potStrobeT strobeBus;
  logic frameValid, writeEnInt, dataBit0;
  logic [CMD_BITS-1:0] cmdField;

  potInputSync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b0001)) uSync (
    .clk(clk), .rstN(rstN),
    .rawIn({hwReset, sdi, sclk, syncN}),
    .syncOut(syncVec)
  );

  potControl #(
    .FRAME_BITS(FRAME_BITS), .WR_PERF_CYCLES(WR_PERF_CYCLES),
    .WR_NORM_CYCLES(WR_NORM_CYCLES), .RD_CYCLES(RD_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .syncLvl(syncVec[0]), .sclkLvl(syncVec[1]), .hwLvl(syncVec[3]),
    .cmdField(cmdField), .dataBit0(dataBit0),
    .writeEn(writeEnInt), .perfMode(perfMode),
    .strobe(strobeBus), .ready(ready), .frameValid(frameValid)
  );

  potDatapath #(.FRAME_BITS(FRAME_BITS), .WIPER_BITS(WIPER_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobeBus),
    .sdiLvl(syncVec[2]), .syncLvl(syncVec[0]),
    .cmdField(cmdField), .dataBit0(dataBit0),
    .wiperCode(wiperCode), .writeEn(writeEnInt), .perfMode(perfMode),
    .shutdown(shutdown), .sdoPullLow(sdoPullLow)
  );
endmodule

// File: rtl/potCoreChecker.sv
module potCoreChecker
  import potPkg::*;
#(
  parameter int WIPER_BITS = 10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ready,
  input logic [WIPER_BITS-1:0] wiperCode,
  input logic                  shutdown,
  input logic                  perfMode,
  input logic                  writeEn,
  input potStrobeT             strobe,
  input logic                  frameValid
);
  localparam logic [WIPER_BITS-1:0] MID_CODE = {1'b1, {(WIPER_BITS-1){1'b0}}};

  assert_locked_wiper_R3: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |=> (wiperCode == $past(wiperCode)) || (wiperCode == MID_CODE));

  assert_sw_reset_defaults_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softReset |=> (wiperCode == MID_CODE) && !writeEn && perfMode);

  assert_hw_reset_mid_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hardReset |=> (wiperCode == MID_CODE));

  assert_shutdown_keeps_wiper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(shutdown) || $fell(shutdown)) && !$past(strobe.hardReset)) |-> $stable(wiperCode));

  assert_busy_after_decode_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(frameValid));

  assert_single_command_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadWiper, strobe.loadCtrl, strobe.softReset, strobe.setShutdown,
              strobe.clrShutdown, strobe.readWiper, strobe.readCtrl}));
endmodule

bind potCore potCoreChecker #(.WIPER_BITS(WIPER_BITS)) uChecker (
  .clk(clk), .rstN(rstN), .ready(ready), .wiperCode(wiperCode),
  .shutdown(shutdown), .perfMode(perfMode), .writeEn(writeEnInt),
  .strobe(strobeBus), .frameValid(frameValid)
);

// File: tb/potCore_test.sv
module potCore_test;
  localparam int WRP = 40;
  localparam int WRN = 12;
  localparam int RDC = 6;

  logic clk = 1'b0;
  logic rstN, hwReset, syncN, sclk, sdi;
  logic sdoPullLow, ready, perfMode, shutdown;
  logic [9:0] wiperCode;
  int vectors = 0;
  int miscompares = 0;
  int busyLow = 0;
  logic [39:0] got;

  always #4 clk = ~clk;

  potCore #(.WR_PERF_CYCLES(WRP), .WR_NORM_CYCLES(WRN), .RD_CYCLES(RDC)) uut (
    .clk(clk), .rstN(rstN), .hwReset(hwReset), .syncN(syncN), .sclk(sclk), .sdi(sdi),
    .sdoPullLow(sdoPullLow), .ready(ready), .wiperCode(wiperCode),
    .perfMode(perfMode), .shutdown(shutdown)
  );

  always @(negedge clk) if (!ready) busyLow++;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [39:0] w, input int n, output logic [39:0] rx);
    rx = '0;
    syncN = 1'b0;
    waitClk(5);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      waitClk(1);
      sclk = 1'b1;
      waitClk(5);
      rx = {rx[38:0], ~sdoPullLow};
      sclk = 1'b0;
      waitClk(5);
    end
    syncN = 1'b1;
    sdi = 1'b0;
    waitClk(6);
  endtask

  task automatic frame(input logic [15:0] w);
    logic [39:0] rx;
    busyLow = 0;
    xfer({24'h0, w}, 16, rx);
    waitClk(WRP + 10);
  endtask

  task automatic tReset;
    check("R6", "wiper", 32'(wiperCode), 32'h200);
    check("R6", "perfMode", 32'(perfMode), 32'h1);
    check("R6", "shutdown", 32'(shutdown), 32'h0);
    check("R6", "ready", 32'(ready), 32'h1);
    check("R6", "sdoPullLow", 32'(sdoPullLow), 32'h0);
  endtask

  task automatic tLocked;
    frame(16'h0455);
    check("R3", "locked write ignored", 32'(wiperCode), 32'h200);
    check("R11", "busy perf write", 32'(busyLow), 32'(WRP));
    frame(16'h0000);
    check("R11", "nop not busy", 32'(busyLow), 32'h0);
  endtask

  task automatic tCtrlWrite;
    frame(16'h1002);
    check("R4", "perf mode kept", 32'(perfMode), 32'h1);
    frame(16'h0555);
    check("R1", "wiper written", 32'(wiperCode), 32'h155);
    check("R11", "busy perf write", 32'(busyLow), 32'(WRP));
    frame(16'h1006);
    check("R4", "normal mode", 32'(perfMode), 32'h0);
    frame(16'h07FF);
    check("R3", "full scale", 32'(wiperCode), 32'h3FF);
    check("R11", "busy normal write", 32'(busyLow), 32'(WRN));
  endtask

  task automatic tReadback;
    frame(16'h0800);
    check("R11", "busy read", 32'(busyLow), 32'(RDC));
    xfer(40'h0, 16, got);
    check("R9", "wiper readback", got[31:0], 32'h03FF);
    frame(16'h1400);
    check("R11", "busy ctrl read", 32'(busyLow), 32'(RDC));
    xfer(40'h0, 16, got);
    check("R9", "ctrl readback", got[31:0], 32'h0006);
    frame(16'h0500);
    frame(16'h0800);
    xfer(40'h0, 16, got);
    check("R9", "quarter scale readback", got[31:0], 32'h0100);
  endtask

  task automatic tDaisy;
    frame(16'h03A5);
    xfer(40'h1C5A, 16, got);
    check("R10", "chain word 1", got[31:0], 32'h03A5);
    xfer(40'h0, 16, got);
    check("R10", "chain word 2", got[31:0], 32'h1C5A);
    check("R2", "nop and unused code", 32'(wiperCode), 32'h100);
  endtask

  task automatic tFraming;
    xfer(40'h0655, 15, got);
    waitClk(10);
    check("R2", "15 bits", 32'(wiperCode), 32'h100);
    xfer(40'h0655, 17, got);
    waitClk(10);
    check("R2", "17 bits", 32'(wiperCode), 32'h100);
    xfer(40'h0655, 31, got);
    waitClk(10);
    check("R2", "31 bits", 32'(wiperCode), 32'h100);
    xfer(40'h0655, 33, got);
    waitClk(10);
    check("R2", "33 bits", 32'(wiperCode), 32'h100);
    xfer(40'h0000_0677, 32, got);
    waitClk(WRP + 10);
    check("R2", "32 bits", 32'(wiperCode), 32'h277);
  endtask

  task automatic tSwReset;
    frame(16'h1004);
    check("R4", "normal locked", 32'(perfMode), 32'h0);
    frame(16'h0C00);
    check("R5", "midscale", 32'(wiperCode), 32'h200);
    check("R5", "perf restored", 32'(perfMode), 32'h1);
    frame(16'h0511);
    check("R5", "lock restored", 32'(wiperCode), 32'h200);
  endtask

  task automatic tHwReset;
    frame(16'h1002);
    frame(16'h0511);
    check("R3", "write", 32'(wiperCode), 32'h111);
    hwReset = 1'b1;
    waitClk(8);
    check("R7", "rise midscale", 32'(wiperCode), 32'h200);
    frame(16'h0522);
    check("R7", "level ignored", 32'(wiperCode), 32'h122);
    hwReset = 1'b0;
    waitClk(8);
    check("R7", "fall ignored", 32'(wiperCode), 32'h122);
    frame(16'h1000);
    hwReset = 1'b1;
    waitClk(8);
    check("R7", "locked midscale", 32'(wiperCode), 32'h200);
    hwReset = 1'b0;
    waitClk(8);
    frame(16'h1400);
    xfer(40'h0, 16, got);
    check("R7", "ctrl untouched", got[31:0], 32'h0000);
  endtask

  task automatic tShutdown;
    frame(16'h1002);
    frame(16'h0544);
    frame(16'h1801);
    check("R8", "enter", 32'(shutdown), 32'h1);
    check("R8", "wiper kept", 32'(wiperCode), 32'h144);
    frame(16'h0533);
    check("R8", "write in shutdown", 32'(wiperCode), 32'h133);
    check("R8", "still shut", 32'(shutdown), 32'h1);
    frame(16'h0800);
    xfer(40'h0, 16, got);
    check("R8", "read in shutdown", got[31:0], 32'h0133);
    frame(16'h1800);
    check("R8", "leave", 32'(shutdown), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0; hwReset = 1'b0; syncN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    tReset();
    tLocked();
    tCtrlWrite();
    tReadback();
    tDaisy();
    tFraming();
    tSwReset();
    tHwReset();
    tShutdown();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule